// File: doc/BRIEF.md
# Tagged Inter-Thread FIFO Cell

This block is one storage cell that several hardware threads share as a small first-in first-out queue. Every access carries a requester number, a read/write direction and a view selector. The view selects how the cell treats the access. The raw view reads or patches entries without moving the queue. The tag view reads or loads the status word. The two flow-controlled views push and pop entries: one of them blocks, the other only tries.

A blocking access that finds the cell empty (on a read) or full (on a write) does not complete. The cell answers it with a stall and sets that requester's bit in a waiter bitmap. The stalled thread is expected to retry the same access after it is woken, because the cell does not hold the request. The next flow-controlled access that completes sends out the whole bitmap as a one-cycle wake pulse and then clears the bitmap. Halting and resuming threads is left to logic outside the cell.

Top module: `itc_fifo_cell`

## Requirements
- R1: After reset the queue holds no entries and the empty flag E is 1. The FIFO flag is 1, T and the full flag F are 0, and the depth code is log2(DEPTH). With the default depth of 8, a tag-view read returns 0x30020001. Every stored entry reads as zero, and rsp_valid, rsp_stall and wake_valid are low.
- R2: A tag-view read (req_view = 1, req_write = 0) packs the tag into the low 32 bits of rsp_rdata: depth code in bits 31:28, entry count in bits 27:18, FIFO flag in bit 17, T in bit 16, F in bit 1 and E in bit 0. All other bits are zero.
- R3: A tag-view write loads T from req_wdata bit 16, F from bit 1 and E from bit 0. When the written E is 1, the entry count is also cleared to zero.
- R4: A flow-controlled read (req_view = 2 blocking, 3 try) that does not stall first clears F. If the cell holds entries, it returns the oldest entry and removes it. It sets E once the count is zero. If the cell holds no entries, it returns zero.
- R5: A flow-controlled write that does not stall first clears E. It appends req_wdata behind the newest entry if the count is below DEPTH, and it sets F once the count equals DEPTH.
- R6: A blocking read while E is 1, or a blocking write while F is 1, returns rsp_stall = 1 with rsp_rdata = 0 and sets bit req_id of the waiter bitmap. It moves no entries. Only the first step of its sequence takes effect: a stalled read still clears F, and a stalled write still clears E.
- R7: A try access never stalls. A try read of an empty cell returns zero. A try write to a full cell is dropped, and the count stays at DEPTH.
- R8: A raw read (req_view = 0) returns the oldest entry without removing it. A raw write replaces the newest entry when the count is above zero. When the count is zero, a raw write changes nothing.
- R9: A flow-controlled access that does not stall, arriving while the waiter bitmap is non-zero, raises wake_valid for exactly one cycle with wake_mask equal to the bitmap, and clears the bitmap.
- R10: Every access is answered in the cycle after it is presented: rsp_valid, rsp_stall, rsp_rdata, wake_valid and wake_mask are registered at the edge that samples the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_view | input | 2 | 0 raw, 1 tag, 2 blocking flow, 3 try flow |
| req_id | input | 5 | Requester number, 0 to NREQ-1 |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Answer to the previous cycle's access |
| rsp_stall | output | 1 | Previous access blocked and was recorded |
| rsp_rdata | output | 64 | Read result of the previous access |
| wake_valid | output | 1 | Wake pulse |
| wake_mask | output | 32 | Requesters to resume |

## Verification
Each result (the answer word, the stall flag and the wake pulse) is due exactly one clock after the edge that samples the request, and the tag update takes effect at that same edge. The bench drives each access on a falling edge and holds it over one rising edge. It reads all outputs on the following falling edge, which is the first point at which the registered answer is visible. The tag state is then read back in the next access's own response cycle. A bench model works out the expected values from the requirements alone. The bench sweeps every fill level from one to DEPTH and drains each one, so the read position wraps through every slot.

// File: rtl/itc_cell_pkg.sv
// Shared definitions for the inter-thread FIFO cell: view codes and the
// bit positions of the packed tag word.
package itc_cell_pkg;
    typedef enum logic [1:0] {
        VIEW_RAW     = 2'd0,
        VIEW_TAG     = 2'd1,
        VIEW_EF_WAIT = 2'd2,
        VIEW_EF_TRY  = 2'd3
    } view_e;

    localparam int unsigned TAG_E_BIT    = 0;
    localparam int unsigned TAG_F_BIT    = 1;
    localparam int unsigned TAG_T_BIT    = 16;
    localparam int unsigned TAG_FIFO_BIT = 17;
    localparam int unsigned TAG_CNT_LSB  = 18;
    localparam int unsigned TAG_CNT_W    = 10;
    localparam int unsigned TAG_DEP_LSB  = 28;
    localparam int unsigned TAG_DEP_W    = 4;
endpackage

// File: rtl/itc_cell_store.sv
// Entry storage for the cell: one write port and one combinational read port.
// Assumes DEPTH is a power of two so that indices wrap by truncation.
module itc_cell_store #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned DATA_W = 64,
    localparam int unsigned PW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Clear all entries on reset, otherwise write the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Present the addressed entry.
    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/itc_cell_waitset.sv
// Waiter bitmap: records stalled requesters and, when asked, sends one wake
// pulse carrying the whole set and then empties it. Assumes a record and a
// wake request never arrive in the same cycle.
module itc_cell_waitset #(
    parameter int unsigned NREQ = 32,
    localparam int unsigned IDW = $clog2(NREQ)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            add_en,
    input  logic [IDW-1:0]  add_id,
    input  logic            wake_req,
    output logic            wake_valid,
    output logic [NREQ-1:0] wake_mask
);
    logic [NREQ-1:0] waiters_q;
    logic            fire;

    // A wake happens only when someone is waiting.
    assign fire = wake_req && (waiters_q != '0);

    // Track the bitmap and register the wake pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiters_q  <= '0;
            wake_valid <= 1'b0;
            wake_mask  <= '0;
        end else begin
            wake_valid <= fire;
            wake_mask  <= fire ? waiters_q : '0;
            if (fire)
                waiters_q <= '0;
            else if (add_en)
                waiters_q <= waiters_q | (NREQ'(1) << add_id);
        end
    end
endmodule

// File: rtl/itc_fifo_cell.sv
// Tagged inter-thread FIFO cell. It decodes the access view, keeps the tag
// (T, E, F, count, read position) and steers the storage and waiter bitmap.
// Every access is answered one cycle later. DEPTH must be a power of two,
// at most 512 so the count fits its tag field.
module itc_fifo_cell
    import itc_cell_pkg::*;
#(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned NREQ   = 32,
    localparam int unsigned PW    = $clog2(DEPTH),
    localparam int unsigned CW    = PW + 1,
    localparam int unsigned IDW   = $clog2(NREQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_view,
    input  logic [IDW-1:0]    req_id,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_stall,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              wake_valid,
    output logic [NREQ-1:0]   wake_mask
);
    view_e            view;
    logic             t_q, e_q, f_q;
    logic             t_d, e_d, f_d;
    logic [CW-1:0]    count_q, cnt_d;
    logic [PW-1:0]    rd_ptr_q, ptr_d;
    logic             is_ef, blocking, ef_rd, ef_wr, ctl_wr, raw_wr_ok;
    logic             stall_now, pop, push, ef_go;
    logic [PW-1:0]    tail_idx, newest_idx, st_idx;
    logic             st_we;
    logic [DATA_W-1:0] head;
    logic [31:0]      tag_word;
    logic [DATA_W-1:0] rd_next;

    assign view = view_e'(req_view);

    // Classify the current access.
    always_comb begin
        is_ef     = (view == VIEW_EF_WAIT) || (view == VIEW_EF_TRY);
        blocking  = (view == VIEW_EF_WAIT);
        ef_rd     = req_valid && is_ef && !req_write;
        ef_wr     = req_valid && is_ef && req_write;
        ctl_wr    = req_valid && (view == VIEW_TAG) && req_write;
        raw_wr_ok = req_valid && (view == VIEW_RAW) && req_write && (count_q != '0);
        stall_now = blocking && ((ef_rd && e_q) || (ef_wr && f_q));
        pop       = ef_rd && !stall_now && (count_q != '0);
        push      = ef_wr && !stall_now && (count_q < CW'(DEPTH));
        ef_go     = (ef_rd || ef_wr) && !stall_now;
    end

    // Storage addressing: the tail for pushes, the newest entry for raw patches.
    always_comb begin
        tail_idx   = rd_ptr_q + PW'(count_q);
        newest_idx = tail_idx - PW'(1);
        st_we      = push || raw_wr_ok;
        st_idx     = push ? tail_idx : newest_idx;
    end

    itc_cell_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_we),
        .wr_idx  (st_idx),
        .wr_data (req_wdata),
        .rd_idx  (rd_ptr_q),
        .rd_data (head)
    );

    itc_cell_waitset #(.NREQ(NREQ)) u_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .add_en     (stall_now),
        .add_id     (req_id),
        .wake_req   (ef_go),
        .wake_valid (wake_valid),
        .wake_mask  (wake_mask)
    );

    // Next tag state, following each view's ordered sequence.
    always_comb begin
        t_d   = t_q;
        e_d   = e_q;
        f_d   = f_q;
        cnt_d = count_q;
        ptr_d = rd_ptr_q;
        if (ctl_wr) begin
            t_d = req_wdata[TAG_T_BIT];
            e_d = req_wdata[TAG_E_BIT];
            f_d = req_wdata[TAG_F_BIT];
            if (req_wdata[TAG_E_BIT]) cnt_d = '0;
        end
        if (ef_rd) begin
            f_d = 1'b0;
            if (pop) begin
                cnt_d = count_q - CW'(1);
                ptr_d = rd_ptr_q + PW'(1);
            end
            if (!stall_now && cnt_d == '0) e_d = 1'b1;
        end
        if (ef_wr) begin
            e_d = 1'b0;
            if (push) cnt_d = count_q + CW'(1);
            if (!stall_now && cnt_d == CW'(DEPTH)) f_d = 1'b1;
        end
    end

    // Register the tag; reset leaves an empty queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q      <= 1'b0;
            e_q      <= 1'b1;
            f_q      <= 1'b0;
            count_q  <= '0;
            rd_ptr_q <= '0;
        end else begin
            t_q      <= t_d;
            e_q      <= e_d;
            f_q      <= f_d;
            count_q  <= cnt_d;
            rd_ptr_q <= ptr_d;
        end
    end

    // Pack the tag word for tag-view reads.
    always_comb begin
        tag_word = '0;
        tag_word[TAG_DEP_LSB +: TAG_DEP_W] = TAG_DEP_W'(PW);
        tag_word[TAG_CNT_LSB +: TAG_CNT_W] = TAG_CNT_W'(count_q);
        tag_word[TAG_FIFO_BIT] = 1'b1;
        tag_word[TAG_T_BIT]    = t_q;
        tag_word[TAG_F_BIT]    = f_q;
        tag_word[TAG_E_BIT]    = e_q;
    end

    // Select the read result for the answer.
    always_comb begin
        rd_next = '0;
        if (req_valid && !req_write) begin
            unique case (view)
                VIEW_RAW:     rd_next = head;
                VIEW_TAG:     rd_next = DATA_W'(tag_word);
                VIEW_EF_WAIT,
                VIEW_EF_TRY:  rd_next = pop ? head : '0;
                default:      rd_next = '0;
            endcase
        end
    end

    // Register the answer one cycle after the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_stall <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_stall <= stall_now;
            rsp_rdata <= rd_next;
        end
    end
endmodule

// File: rtl/itc_fifo_cell_chk.sv
// Checker for the FIFO cell: timing of answers, stall behaviour and the
// wake pulse. Attached to every instance of the top by the bind below.
module itc_fifo_cell_chk #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned NREQ   = 32,
    parameter int unsigned CW     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_view,
    input logic              rsp_valid,
    input logic              rsp_stall,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              wake_valid,
    input logic [NREQ-1:0]   wake_mask,
    input logic [CW-1:0]     cnt,
    input logic              e_flag
);
    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R10
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R6
    wait_read_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_view == 2'd2 && !req_write && e_flag) |=> rsp_stall);
    // R6
    stall_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_stall |-> (rsp_rdata == '0));
    // R7
    try_never_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_view == 2'd3) |=> !rsp_stall);
    // R9
    wake_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> (wake_mask != '0));
    // R9
    wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |=> !wake_valid);
    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
endmodule

bind itc_fifo_cell itc_fifo_cell_chk #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .NREQ(NREQ), .CW(CW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_view   (req_view),
    .rsp_valid  (rsp_valid),
    .rsp_stall  (rsp_stall),
    .rsp_rdata  (rsp_rdata),
    .wake_valid (wake_valid),
    .wake_mask  (wake_mask),
    .cnt        (count_q),
    .e_flag     (e_q)
);

// File: tb/itc_fifo_cell_test.sv
// Bench for the FIFO cell: a requirement-level model predicts every answer.
module itc_fifo_cell_test;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_view = 2'd0;
    logic [4:0]  req_id = 5'd0;
    logic [63:0] req_wdata = 64'd0;
    logic        rsp_valid, rsp_stall, wake_valid;
    logic [63:0] rsp_rdata;
    logic [31:0] wake_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] mq [$];
    logic        m_t = 1'b0, m_e = 1'b1, m_f = 1'b0;
    logic [31:0] m_map = 32'd0;

    itc_fifo_cell uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_view(req_view), .req_id(req_id), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_stall(rsp_stall), .rsp_rdata(rsp_rdata),
        .wake_valid(wake_valid), .wake_mask(wake_mask)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model_tag();
        logic [31:0] w;
        w = {4'd3, 10'(mq.size()), 1'b1, m_t, 14'd0, m_f, m_e};
        return 64'(w);
    endfunction

    // One access: predict from the model, drive, then sample the answer.
    task automatic op(input logic [1:0] v, input logic w, input logic [4:0] id,
                      input logic [63:0] d, input string tag);
        logic [63:0] e_rd = 64'd0;
        logic        e_st = 1'b0;
        logic        e_wk = 1'b0;
        logic [31:0] e_mk = 32'd0;
        case (v)
            2'd0: begin
                if (!w) e_rd = (mq.size() > 0) ? mq[0] : 64'd0;
                else if (mq.size() > 0) mq[mq.size()-1] = d;
            end
            2'd1: begin
                if (!w) e_rd = model_tag();
                else begin
                    m_t = d[16]; m_e = d[0]; m_f = d[1];
                    if (d[0]) mq.delete();
                end
            end
            default: begin
                if (!w) begin
                    m_f = 1'b0;
                    if (v == 2'd2 && m_e) begin
                        e_st = 1'b1; m_map |= (32'd1 << id);
                    end else begin
                        if (m_map != 0) begin e_wk = 1'b1; e_mk = m_map; m_map = 0; end
                        if (mq.size() > 0) e_rd = mq.pop_front();
                        if (mq.size() == 0) m_e = 1'b1;
                    end
                end else begin
                    m_e = 1'b0;
                    if (v == 2'd2 && m_f) begin
                        e_st = 1'b1; m_map |= (32'd1 << id);
                    end else begin
                        if (m_map != 0) begin e_wk = 1'b1; e_mk = m_map; m_map = 0; end
                        if (mq.size() < DEPTH) mq.push_back(d);
                        if (mq.size() == DEPTH) m_f = 1'b1;
                    end
                end
            end
        endcase
        req_valid = 1'b1; req_write = w; req_view = v; req_id = id; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " rdata"}, rsp_rdata, e_rd);
        check({tag, " stall"}, 64'(rsp_stall), 64'(e_st));
        check("R9 wake_valid", 64'(wake_valid), 64'(e_wk));
        check("R9 wake_mask", 64'(wake_mask), 64'(e_mk));
        check("R10 rsp_valid", 64'(rsp_valid), 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset outputs and tag word
        check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1 wake_valid", 64'(wake_valid), 64'd0);
        check("R1 rsp_stall", 64'(rsp_stall), 64'd0);
        op(2'd1, 1'b0, 5'd0, 64'd0, "R1");
        check("R1 tag constant", rsp_rdata, 64'h0000_0000_3002_0001);
        op(2'd0, 1'b0, 5'd0, 64'd0, "R1");

        // R5 / R4 sweep over every fill level; read position wraps
        for (int n = 1; n <= DEPTH; n++) begin
            for (int i = 0; i < n; i++)
                op(2'd3, 1'b1, 5'd1, 64'hA500_0000_0000_0000 | 64'(n << 8) | 64'(i), "R5");
            op(2'd1, 1'b0, 5'd0, 64'd0, "R2");
            op(2'd0, 1'b0, 5'd0, 64'd0, "R8");
            for (int i = 0; i < n; i++)
                op(2'd2, 1'b0, 5'd2, 64'd0, "R4");
            op(2'd3, 1'b0, 5'd2, 64'd0, "R7");
            op(2'd1, 1'b0, 5'd0, 64'd0, "R2");
        end

        // R7 full cell: dropped try write, then R6 blocking writes stall
        for (int i = 0; i < DEPTH; i++)
            op(2'd3, 1'b1, 5'd1, 64'h1111_0000_0000_0000 + 64'(i), "R5");
        op(2'd3, 1'b1, 5'd1, 64'hBAD0_BAD0_BAD0_BAD0, "R7");
        op(2'd1, 1'b0, 5'd0, 64'd0, "R7");
        op(2'd2, 1'b1, 5'd5, 64'h5555, "R6");
        op(2'd2, 1'b1, 5'd9, 64'h9999, "R6");
        op(2'd1, 1'b0, 5'd0, 64'd0, "R6");
        op(2'd3, 1'b0, 5'd4, 64'd0, "R9");
        for (int i = 1; i < DEPTH; i++)
            op(2'd2, 1'b0, 5'd4, 64'd0, "R4");

        // R6 blocking reads of the empty cell, woken by a write (R9)
        op(2'd2, 1'b0, 5'd3, 64'd0, "R6");
        op(2'd2, 1'b0, 5'd17, 64'd0, "R6");
        op(2'd2, 1'b0, 5'd31, 64'd0, "R6");
        op(2'd3, 1'b1, 5'd0, 64'h0123_4567_89AB_CDEF, "R9");
        op(2'd0, 1'b1, 5'd0, 64'hDEAD_BEEF_0000_0001, "R8");
        op(2'd0, 1'b0, 5'd0, 64'd0, "R8");
        op(2'd1, 1'b0, 5'd0, 64'd0, "R8");
        op(2'd2, 1'b0, 5'd0, 64'd0, "R8");
        op(2'd0, 1'b1, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
        op(2'd1, 1'b0, 5'd0, 64'd0, "R8");

        // R3 tag writes
        for (int i = 0; i < 3; i++)
            op(2'd2, 1'b1, 5'd6, 64'h7700 + 64'(i), "R5");
        op(2'd1, 1'b1, 5'd0, 64'h0001_0002, "R3");
        op(2'd1, 1'b0, 5'd0, 64'd0, "R3");
        op(2'd2, 1'b1, 5'd12, 64'h1212, "R6");
        op(2'd1, 1'b0, 5'd0, 64'd0, "R6");
        op(2'd1, 1'b1, 5'd0, 64'h0001_0001, "R3");
        op(2'd1, 1'b0, 5'd0, 64'd0, "R3");
        op(2'd1, 1'b1, 5'd0, 64'h0000_0000, "R3");
        op(2'd1, 1'b0, 5'd0, 64'd0, "R3");
        op(2'd2, 1'b0, 5'd7, 64'd0, "R4");
        op(2'd1, 1'b0, 5'd0, 64'd0, "R4");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule